// File: doc/BRIEF.md
# Programmable Square-Wave Clock Generator

This block produces a square wave with equal high and low times from a 16-bit up-counter that reloads itself. The counter starts from a software-chosen reload value and counts up. When it passes its all-ones state it wraps: it takes the reload value again and the output pin changes state. One full output period therefore spans two wraps, and the output frequency is the count rate divided by 2 × (65536 − reload).

The count rate is either the system clock or half of it. The half rate comes from a count enable that fires on every other cycle, so the whole block runs on one clock. The generator runs only when the capture/reload mode bit is 0 and the output-enable bit is 1. In any other setting the pin is held low and the counter waits at the reload value.

Every wrap sets a sticky overflow flag, which stays set until a clear strobe arrives. An interrupt request follows the flag. A separate ignore bit can mask that request without stopping the flag from being set.

Top module: `sqclk_gen`

## Requirements
- R1: The generator is active only when `cap_mode` is 0 and `out_en` is 1. While inactive, `clk_out` is 0 from the first clock edge after the inactive setting is sampled.
- R2: With `src_full_rate` = 1, the counter advances on every clock cycle while active.
- R3: With `src_full_rate` = 0, the counter advances on every second clock cycle while active, so each output level lasts 2 × (65536 − reload) cycles.
- R4: When the counter advances from 0xFFFF, it loads `reload_val` and `clk_out` toggles. At full rate each output level lasts 65536 − reload cycles.
- R5: In steady state, the high and low times of `clk_out` are equal.
- R6: Every wrap sets `ovf_flag`. The flag stays set until `flag_clr` is sampled high. If a wrap and a clear happen in the same cycle, the set wins.
- R7: `irq_req` is high exactly when `ovf_flag` is 1 and `irq_ignore` is 0. `irq_ignore` has no effect on `ovf_flag`.
- R8: While inactive, the counter is held at `reload_val` and the output toggle is cleared. After reactivation, the first high level starts a full 65536 − reload counts later.
- R9: After reset, `clk_out`, `ovf_flag` and `irq_req` are all 0.
- R10: `reload_val` is sampled at the moment of each wrap. A new value therefore first shapes the output level after the one already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_full_rate | input | 1 | 1: count every cycle, 0: count every second cycle |
| cap_mode | input | 1 | Capture/reload mode bit; must be 0 for clock output |
| out_en | input | 1 | Output enable; must be 1 for clock output |
| reload_val | input | 16 | Reload value loaded on each wrap |
| flag_clr | input | 1 | Clears the overflow flag |
| irq_ignore | input | 1 | Masks the interrupt request |
| clk_out | output | 1 | Square-wave output |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq_req | output | 1 | Interrupt request |

## Verification
The output is driven at full rate and at half rate with reload values that give short periods. Comparing the level lengths at the two rates tells the per-cycle count enable apart from the every-other-cycle enable. It also shows whether both levels of one period are equal.

The reload value is changed in the middle of a level. This tells a reload taken at the wrap apart from one taken at any other time. The generator is also switched off in the middle of a level, and both disabling combinations of the mode and enable bits are tried. This shows whether the toggle really resets and whether the counter restarts from the reload value.

Holding the clear strobe high across wraps checks the priority of set over clear. Raising the ignore bit while the flag is set separates masking the request from blocking the flag.

// File: rtl/sqclk_pkg.sv
package sqclk_pkg;

    // State of the rate prescaler
    typedef struct packed {
        logic phase;
    } pre_st_t;

    // State of the output stage
    typedef struct packed {
        logic tog;
        logic flag;
    } out_st_t;

    localparam pre_st_t PRE_RST = '{phase: 1'b0};
    localparam out_st_t OUT_RST = '{tog: 1'b0, flag: 1'b0};

endpackage

// File: rtl/sqclk_prescale.sv
module sqclk_prescale
    import sqclk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic full_rate,
    output logic tick
);
    pre_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (!run) begin
            st_d.phase = 1'b0;
        end else begin
            st_d.phase = ~st_q.phase;
            tick       = full_rate ? 1'b1 : st_q.phase;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= PRE_RST;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/sqclk_counter.sv
module sqclk_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    output logic             wrap,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (!run) begin
            st_d.cnt = reload;
        end else if (tick) begin
            if (st_q.cnt == CNT_MAX) begin
                wrap     = 1'b1;
                st_d.cnt = reload;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/sqclk_outstage.sv
module sqclk_outstage
    import sqclk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic wrap,
    input  logic clr,
    output logic tog,
    output logic flag
);
    out_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run)      st_d.tog = 1'b0;
        else if (wrap) st_d.tog = ~st_q.tog;
        // set has priority over clear
        if (wrap)      st_d.flag = 1'b1;
        else if (clr)  st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= OUT_RST;
        else     st_q <= st_d;
    end

    assign tog  = st_q.tog;
    assign flag = st_q.flag;
endmodule

// File: rtl/sqclk_gen.sv
module sqclk_gen #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             src_full_rate,
    input  logic             cap_mode,
    input  logic             out_en,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             flag_clr,
    input  logic             irq_ignore,
    output logic             clk_out,
    output logic             ovf_flag,
    output logic             irq_req
);
    logic             run;
    logic             tick;
    logic             wrap;
    logic [CNT_W-1:0] cnt;

    assign run = ~cap_mode & out_en;

    sqclk_prescale u_pre (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .full_rate (src_full_rate),
        .tick      (tick)
    );

    sqclk_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .tick   (tick),
        .reload (reload_val),
        .wrap   (wrap),
        .cnt    (cnt)
    );

    sqclk_outstage u_out (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .wrap (wrap),
        .clr  (flag_clr),
        .tog  (clk_out),
        .flag (ovf_flag)
    );

    assign irq_req = ovf_flag & ~irq_ignore;
endmodule

// File: rtl/sqclk_gen_checker.sv
module sqclk_gen_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             src_full_rate,
    input logic             cap_mode,
    input logic             out_en,
    input logic [CNT_W-1:0] reload_val,
    input logic             flag_clr,
    input logic             irq_ignore,
    input logic             clk_out,
    input logic             ovf_flag,
    input logic             irq_req,
    input logic             tick,
    input logic             wrap,
    input logic [CNT_W-1:0] cnt
);
    assert_inactive_low_R1: assert property (@(posedge clk) disable iff (rst)
        (cap_mode || !out_en) |=> !clk_out);

    assert_half_rate_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !src_full_rate) |=> (src_full_rate || !tick));

    assert_reload_on_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt == $past(reload_val)));

    assert_flag_on_toggle_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_out) |-> ovf_flag);

    assert_flag_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !flag_clr) |=> ovf_flag);

    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (rst)
        irq_ignore |-> !irq_req);
endmodule

bind sqclk_gen sqclk_gen_checker #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .src_full_rate (src_full_rate),
    .cap_mode      (cap_mode),
    .out_en        (out_en),
    .reload_val    (reload_val),
    .flag_clr      (flag_clr),
    .irq_ignore    (irq_ignore),
    .clk_out       (clk_out),
    .ovf_flag      (ovf_flag),
    .irq_req       (irq_req),
    .tick          (tick),
    .wrap          (wrap),
    .cnt           (cnt)
);

// File: tb/sqclk_gen_tb_top.sv
module sqclk_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        src_full_rate = 1'b1;
    logic        cap_mode = 1'b0;
    logic        out_en = 1'b0;
    logic [15:0] reload_val = 16'hFFF0;
    logic        flag_clr = 1'b0;
    logic        irq_ignore = 1'b0;
    logic        clk_out, ovf_flag, irq_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    int  m_cnt = 0;
    bit  m_phase = 0;
    bit  m_tog = 0;
    bit  m_flag = 0;

    always #5 clk = ~clk;

    sqclk_gen dut_i (
        .clk(clk), .rst(rst), .src_full_rate(src_full_rate), .cap_mode(cap_mode),
        .out_en(out_en), .reload_val(reload_val), .flag_clr(flag_clr),
        .irq_ignore(irq_ignore), .clk_out(clk_out), .ovf_flag(ovf_flag), .irq_req(irq_req)
    );

    // Behavioural model: counting rules taken from the requirements
    always @(posedge clk) begin
        bit adv, wrapped;
        wrapped = 0;
        if (rst) begin
            m_cnt = 0; m_phase = 0; m_tog = 0; m_flag = 0;
        end else if (cap_mode || !out_en) begin
            m_cnt = reload_val; m_phase = 0; m_tog = 0;           // R8
            if (flag_clr) m_flag = 0;
        end else begin
            adv = src_full_rate ? 1'b1 : m_phase;                 // R2 R3
            m_phase = !m_phase;
            if (adv) begin
                if (m_cnt == 65535) begin
                    m_cnt = reload_val; m_tog = !m_tog; wrapped = 1;  // R4 R10
                end else m_cnt = m_cnt + 1;
            end
            if (wrapped) m_flag = 1;                              // R6
            else if (flag_clr) m_flag = 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(clk_out == m_tog, "R4 clk_out", clk_out, m_tog);
            check(ovf_flag == m_flag, "R6 ovf_flag", ovf_flag, m_flag);
            check(irq_req == (m_flag && !irq_ignore), "R7 irq_req", irq_req, m_flag && !irq_ignore);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic measure(output int n);
        logic s;
        s = clk_out;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (clk_out == s && n < 2000);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check(clk_out == 0 && ovf_flag == 0 && irq_req == 0, "R9 reset state",
              {clk_out, ovf_flag, irq_req}, 0);
        rst = 1'b0;
        repeat (30) @(negedge clk);
        check(clk_out == 0, "R1 out_en=0 holds low", clk_out, 0);
        cap_mode = 1'b1; out_en = 1'b1;
        repeat (40) @(negedge clk);
        check(clk_out == 0 && ovf_flag == 0, "R1 cap_mode=1 holds low", clk_out, 0);
        cap_mode = 1'b0;
        measure(n); check(n == 16, "R2 R8 first level full rate", n, 16);
        measure(n); check(n == 16, "R4 R5 high time", n, 16);
        measure(n); check(n == 16, "R5 low time", n, 16);
        check(ovf_flag == 1, "R6 flag set by wrap", ovf_flag, 1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check(ovf_flag == 0, "R6 flag cleared", ovf_flag, 0);
        irq_ignore = 1'b1;
        measure(n);
        check(ovf_flag == 1, "R7 ignore leaves flag", ovf_flag, 1);
        check(irq_req == 0, "R7 irq masked", irq_req, 0);
        irq_ignore = 1'b0;
        #1 check(irq_req == 1, "R7 irq unmasked", irq_req, 1);
        src_full_rate = 1'b0;
        measure(n);
        measure(n); check(n == 32, "R3 half-rate level", n, 32);
        measure(n); check(n == 32, "R3 R5 half-rate other level", n, 32);
        src_full_rate = 1'b1;
        measure(n);
        reload_val = 16'hFFF8;
        measure(n); check(n == 16, "R10 running level keeps old reload", n, 16);
        measure(n); check(n == 8, "R10 new reload applied", n, 8);
        repeat (3) @(negedge clk);
        out_en = 1'b0;
        @(negedge clk);
        check(clk_out == 0, "R1 R8 disable mid-level", clk_out, 0);
        repeat (5) @(negedge clk);
        out_en = 1'b1;
        measure(n); check(n == 8, "R8 restart full level", n, 8);
        flag_clr = 1'b1;                                          // R6 set beats held clear
        repeat (40) @(negedge clk);
        flag_clr = 1'b0;
        repeat (4) @(negedge clk);
        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule